// File: doc/BRIEF.md
# Pin-Driven Standby Power Controller

This block sequences a chip into and out of a deep standby mode that an active-low external standby pin requests. While the chip is in this mode, the oscillator, the clock tree and the CPU are held off. General-purpose outputs are released to high impedance with their pull-ups disabled. The status pin either keeps driving or floats, according to a control bit that is captured when the mode is entered. The real-time-clock enable stays on throughout. The mode can be left only by a power-on sequence driven through the pins: the reset pin goes low, the mode-select pin goes high, and then a rising standby pin restarts the oscillator. The CPU is released once the reset pin rises while the clock is stable.

The controller also follows the instruction-entered standby of the surrounding chip. From clock-stopped software standby it moves straight into pin standby without waking the oscillator. If the watchdog is timing an interrupt wake-up, it first lets the CPU run for one cycle and then enters pin standby. Asynchronous pins pass through two-flop synchronisers. The state register is one-hot, and all control outputs come from registers.

Top module: `hw_stby_ctrl`

## Requirements
- R1: When the synchronised standby pin is low in run state, the block enters pin standby. `osc_en_o`, `clk_en_o` and `cpu_run_o` are 0 there.
- R2: In pin standby, `irq_i` and `mrst_i` have no effect. The block stays in pin standby.
- R3: In pin standby and during oscillator restart, `out_hiz_o`=1 and `pullup_en_o`=0. In every other state, `out_hiz_o`=0 and `pullup_en_o`=1.
- R4: In pin standby, `stat_oe_o` is the inverse of `stat_hiz_i` as sampled on entry: 1 means the status pin floats, 0 means it drives.
- R5: If the standby pin goes low in software standby, the block enters pin standby and `osc_en_o` stays 0 on every cycle along the way.
- R6: If the standby pin goes low while the watchdog is timing a wake-up, `cpu_run_o` is high for exactly one cycle, and then the block is in pin standby.
- R7: A rising standby pin, seen while the reset pin is low and `msel_i` is high, moves the block from pin standby to oscillator restart: `osc_en_o`=1, `cpu_run_o`=0, `out_hiz_o`=1.
- R8: During oscillator restart, the block returns to run, with all enables 1 and `out_hiz_o`=0, at the first cycle in which the reset pin is high and `clk_stable_i` is 1.
- R9: `rtc_en_o` is 1 at all times, including throughout pin standby.
- R10: A standby-pin rising edge that arrives while the reset pin is high or `msel_i` is low is discarded. Meeting the conditions later, while the pin is still held high, does not cause an exit.
- R11: A change on `stby_ni` reaches the control outputs on the fourth rising clock edge after it, and not earlier.
- R12: Changes to `stat_hiz_i` during pin standby do not alter `stat_oe_o`.
- R13: After `rst_ni` is released, the block is in run state: all enables 1, `out_hiz_o`=0, `stat_oe_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| stby_ni | input | 1 | External standby request pin, active low, asynchronous |
| por_ni | input | 1 | External power-on reset pin, active low, asynchronous |
| msel_i | input | 1 | External mode-select pin, asynchronous |
| clk_stable_i | input | 1 | Oscillator stable indication, asynchronous |
| sw_stby_i | input | 1 | Software standby entry request |
| irq_i | input | 1 | Interrupt wake-up request |
| mrst_i | input | 1 | Manual reset request |
| wdt_done_i | input | 1 | Watchdog finished timing the wake-up |
| stat_hiz_i | input | 1 | Control bit: status pin floats in pin standby |
| osc_en_o | output | 1 | Oscillator enable |
| clk_en_o | output | 1 | Clock tree enable |
| cpu_run_o | output | 1 | CPU run enable |
| out_hiz_o | output | 1 | Global output high-impedance control |
| pullup_en_o | output | 1 | Pull-up enable |
| stat_oe_o | output | 1 | Status pin output enable |
| rtc_en_o | output | 1 | Real-time clock enable |

## Verification
The assertions check on every cycle the properties that hold from state alone. The state stays one-hot. Pin standby persists while the synchronised standby pin is low, whatever the interrupt and reset requests do. The one-cycle CPU run is always followed by pin standby. The captured status bit does not move during standby. The output registers follow the state, including the tri-state and pull-up pairing and the always-on real-time clock. Only the bench scenarios can show the pin ordering across many cycles. These include an early or unqualified rising edge that is discarded, the oscillator staying dark across a software-standby entry, the exact four-edge latency from pin to output, and the full power-on exit with a late clock-stable indication.

// File: rtl/hw_stby_pkg.sv
package hw_stby_pkg;
  localparam int N_ST  = 6;
  localparam int S_RUN = 0;  // clocks running
  localparam int S_SW  = 1;  // software standby, clock stopped
  localparam int S_WDT = 2;  // watchdog timing a wake-up
  localparam int S_BRF = 3;  // one-cycle CPU restart before pin standby
  localparam int S_HW  = 4;  // pin standby
  localparam int S_OSC = 5;  // oscillator restart awaiting reset release

  typedef logic [N_ST-1:0] st_vec_t;

  function automatic st_vec_t st_oh(input int idx);
    st_vec_t v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int           W       = 4,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[b]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import hw_stby_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    stby_s_i,
  input  logic    por_s_i,
  input  logic    msel_s_i,
  input  logic    stable_s_i,
  input  logic    sw_stby_i,
  input  logic    irq_i,
  input  logic    mrst_i,
  input  logic    wdt_done_i,
  input  logic    stat_hiz_i,
  output st_vec_t st_o,
  output logic    hiz_lat_o
);
  st_vec_t st_q, st_d;
  logic    stby_q, hiz_lat_q;
  logic    stby_rise;

  assign stby_rise = stby_s_i && !stby_q;

  always_comb begin
    st_d = st_q;
    case (1'b1)
      st_q[S_RUN]: if (!stby_s_i) st_d = st_oh(S_HW);
                   else if (sw_stby_i) st_d = st_oh(S_SW);
      st_q[S_SW]:  if (!stby_s_i) st_d = st_oh(S_HW);
                   else if (mrst_i) st_d = st_oh(S_RUN);
                   else if (irq_i) st_d = st_oh(S_WDT);
      st_q[S_WDT]: if (!stby_s_i) st_d = st_oh(S_BRF);
                   else if (wdt_done_i) st_d = st_oh(S_RUN);
      st_q[S_BRF]: st_d = st_oh(S_HW);
      st_q[S_HW]:  if (stby_rise && !por_s_i && msel_s_i) st_d = st_oh(S_OSC);
      st_q[S_OSC]: if (!stby_s_i) st_d = st_oh(S_HW);
                   else if (por_s_i && stable_s_i) st_d = st_oh(S_RUN);
      default:     st_d = st_oh(S_RUN);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= st_oh(S_RUN);
      stby_q    <= 1'b1;
      hiz_lat_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      stby_q <= stby_s_i;
      // capture only on entry from outside the standby episode
      if (st_d[S_HW] && !st_q[S_HW] && !st_q[S_OSC]) hiz_lat_q <= stat_hiz_i;
    end
  end

  assign st_o      = st_q;
  assign hiz_lat_o = hiz_lat_q;

  st_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_q) == 1);

  // R1
  run_to_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[S_RUN] && !stby_s_i) |=> st_q[S_HW]);

  // R2
  hw_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[S_HW] && !stby_s_i) |=> st_q[S_HW]);

  // R5
  sw_to_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[S_SW] && !stby_s_i) |=> st_q[S_HW]);

  // R6
  wdt_to_brf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[S_WDT] && !stby_s_i) |=> st_q[S_BRF]);

  // R6
  brf_to_hw_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q[S_BRF] |=> st_q[S_HW]);

  // R8
  por_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[S_OSC] && stby_s_i && por_s_i && stable_s_i) |=> st_q[S_RUN]);

  // R12
  lat_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q[S_HW] && st_d[S_HW]) |=> $stable(hiz_lat_q));
endmodule

// File: rtl/stby_out_dec.sv
module stby_out_dec
  import hw_stby_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  st_vec_t st_i,
  input  logic    hiz_lat_i,
  output logic    osc_en_o,
  output logic    clk_en_o,
  output logic    cpu_run_o,
  output logic    out_hiz_o,
  output logic    pullup_en_o,
  output logic    stat_oe_o,
  output logic    rtc_en_o
);
  logic pin_phase, run_like;

  assign pin_phase = st_i[S_HW] || st_i[S_OSC];
  assign run_like  = st_i[S_RUN] || st_i[S_BRF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_en_o    <= 1'b1;
      clk_en_o    <= 1'b1;
      cpu_run_o   <= 1'b1;
      out_hiz_o   <= 1'b0;
      pullup_en_o <= 1'b1;
      stat_oe_o   <= 1'b1;
      rtc_en_o    <= 1'b1;
    end else begin
      osc_en_o    <= run_like || st_i[S_WDT] || st_i[S_OSC];
      clk_en_o    <= run_like;
      cpu_run_o   <= run_like;
      out_hiz_o   <= pin_phase;
      pullup_en_o <= !pin_phase;
      stat_oe_o   <= pin_phase ? !hiz_lat_i : 1'b1;
      rtc_en_o    <= 1'b1;
    end
  end

  // R1
  hw_clk_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i[S_HW] |=> (!osc_en_o && !clk_en_o && !cpu_run_o));

  // R3
  hw_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_phase |=> (out_hiz_o && !pullup_en_o));

  // R3
  run_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pin_phase |=> (!out_hiz_o && pullup_en_o));

  // R4
  stat_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i[S_HW] |=> (stat_oe_o == !$past(hiz_lat_i)));

  // R5
  sw_osc_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i[S_SW] |=> !osc_en_o);

  // R9
  rtc_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i[S_HW] |=> rtc_en_o);
endmodule

// File: rtl/hw_stby_ctrl.sv
module hw_stby_ctrl
  import hw_stby_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stby_ni,
  input  logic por_ni,
  input  logic msel_i,
  input  logic clk_stable_i,
  input  logic sw_stby_i,
  input  logic irq_i,
  input  logic mrst_i,
  input  logic wdt_done_i,
  input  logic stat_hiz_i,
  output logic osc_en_o,
  output logic clk_en_o,
  output logic cpu_run_o,
  output logic out_hiz_o,
  output logic pullup_en_o,
  output logic stat_oe_o,
  output logic rtc_en_o
);
  localparam int N_PIN = 4;

  logic [N_PIN-1:0] pin_raw, pin_s;
  st_vec_t          st;
  logic             hiz_lat;

  // bit order: stable, msel, por, stby
  assign pin_raw = {clk_stable_i, msel_i, por_ni, stby_ni};

  pin_sync #(.W(N_PIN), .STAGES(2), .RST_VAL(4'b0011)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_raw),
    .q_o   (pin_s)
  );

  stby_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .stby_s_i  (pin_s[0]),
    .por_s_i   (pin_s[1]),
    .msel_s_i  (pin_s[2]),
    .stable_s_i(pin_s[3]),
    .sw_stby_i (sw_stby_i),
    .irq_i     (irq_i),
    .mrst_i    (mrst_i),
    .wdt_done_i(wdt_done_i),
    .stat_hiz_i(stat_hiz_i),
    .st_o      (st),
    .hiz_lat_o (hiz_lat)
  );

  stby_out_dec u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .st_i       (st),
    .hiz_lat_i  (hiz_lat),
    .osc_en_o   (osc_en_o),
    .clk_en_o   (clk_en_o),
    .cpu_run_o  (cpu_run_o),
    .out_hiz_o  (out_hiz_o),
    .pullup_en_o(pullup_en_o),
    .stat_oe_o  (stat_oe_o),
    .rtc_en_o   (rtc_en_o)
  );
endmodule

// File: tb/tb_hw_stby_ctrl.sv
module tb_hw_stby_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby_n = 1'b1, por_n = 1'b1, msel = 1'b0, stable = 1'b1;
  logic sw_stby = 1'b0, irq = 1'b0, mrst = 1'b0, wdt_done = 1'b0, hiz_bit = 1'b0;
  logic osc_en, clk_en, cpu_run, out_hiz, pullup_en, stat_oe, rtc_en;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  hw_stby_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .stby_ni(stby_n), .por_ni(por_n),
    .msel_i(msel), .clk_stable_i(stable), .sw_stby_i(sw_stby), .irq_i(irq),
    .mrst_i(mrst), .wdt_done_i(wdt_done), .stat_hiz_i(hiz_bit),
    .osc_en_o(osc_en), .clk_en_o(clk_en), .cpu_run_o(cpu_run),
    .out_hiz_o(out_hiz), .pullup_en_o(pullup_en), .stat_oe_o(stat_oe),
    .rtc_en_o(rtc_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // packed view {osc,clk,cpu,hiz,pullup,stat_oe,rtc}
  function automatic logic [6:0] outs();
    return {osc_en, clk_en, cpu_run, out_hiz, pullup_en, stat_oe, rtc_en};
  endfunction

  task automatic t_reset();
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R13 reset outputs", outs(), 7'b1110111);
  endtask

  task automatic t_enter_run(input logic bit_v);
    hiz_bit = bit_v;
    stby_n  = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R11 no change after 3 edges", out_hiz, 1'b0);
    wait_cyc(1);
    chk("R11 change on 4th edge", out_hiz, 1'b1);
    chk("R1 clocks off in standby", {osc_en, clk_en, cpu_run}, 3'b000);
    chk("R3 hiz and pullups off", {out_hiz, pullup_en}, 2'b10);
    chk("R4 status pin per bit", stat_oe, !bit_v);
    chk("R9 rtc on in standby", rtc_en, 1'b1);
  endtask

  task automatic t_ignore_wake();
    irq = 1'b1; mrst = 1'b1; hiz_bit = ~hiz_bit;
    wait_cyc(3);
    irq = 1'b0; mrst = 1'b0;
    wait_cyc(4);
    chk("R2 still in standby after irq/mrst", {osc_en, cpu_run, out_hiz}, 3'b001);
    chk("R12 stat_oe unaffected by bit change", stat_oe, hiz_bit);
    hiz_bit = ~hiz_bit;
  endtask

  task automatic t_bad_exit();
    por_n = 1'b1; msel = 1'b1;
    wait_cyc(3);
    stby_n = 1'b1;
    wait_cyc(6);
    chk("R10 rise with reset high ignored", {osc_en, out_hiz}, 2'b01);
    por_n = 1'b0;
    wait_cyc(6);
    chk("R10 late conditions ignored", {osc_en, out_hiz}, 2'b01);
    stby_n = 1'b0;
    wait_cyc(6);
  endtask

  task automatic t_exit();
    stable = 1'b0; por_n = 1'b0; msel = 1'b1;
    wait_cyc(3);
    stby_n = 1'b1;
    wait_cyc(6);
    chk("R7 oscillator restart", {osc_en, cpu_run, out_hiz}, 3'b101);
    chk("R3 hiz during restart", pullup_en, 1'b0);
    por_n = 1'b1;
    wait_cyc(6);
    chk("R8 no release before clock stable", {cpu_run, out_hiz}, 2'b01);
    stable = 1'b1;
    wait_cyc(6);
    chk("R8 release to run", outs(), 7'b1110111);
    msel = 1'b0;
  endtask

  task automatic t_sw_path();
    int osc_hits = 0;
    sw_stby = 1'b1;
    wait_cyc(1);
    sw_stby = 1'b0;
    wait_cyc(2);
    chk("R5 software standby osc off", {osc_en, out_hiz}, 2'b00);
    hiz_bit = 1'b0;
    stby_n = 1'b0;
    for (int i = 0; i < 8; i++) begin
      wait_cyc(1);
      if (osc_en) osc_hits++;
    end
    chk("R5 oscillator never on", osc_hits, 0);
    chk("R5 in pin standby", out_hiz, 1'b1);
    chk("R4 status drives when bit clear", stat_oe, 1'b1);
  endtask

  task automatic t_wdt_path();
    int run_cyc = 0;
    sw_stby = 1'b1;
    wait_cyc(1);
    sw_stby = 1'b0;
    irq = 1'b1;
    wait_cyc(1);
    irq = 1'b0;
    wait_cyc(2);
    chk("R6 watchdog wait osc on cpu off", {osc_en, cpu_run}, 2'b10);
    stby_n = 1'b0;
    for (int i = 0; i < 10; i++) begin
      wait_cyc(1);
      if (cpu_run) run_cyc++;
    end
    chk("R6 single cpu cycle", run_cyc, 1);
    chk("R6 then pin standby", {cpu_run, out_hiz}, 2'b01);
  endtask

  initial begin
    t_reset();
    t_enter_run(1'b1);
    t_ignore_wake();
    t_bad_exit();
    t_exit();
    t_sw_path();
    t_exit();
    t_wdt_path();
    t_exit();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule